// File: doc/BRIEF.md
# Split-Lane Even Parity Checker

This block watches a multiplexed address/data bus that is 64 bits wide, with 8 command/byte-enable lines, and reports parity faults. The bus is checked as two independent 32-bit lanes. The lower lane covers address/data bits 31:0, command/byte-enable bits 3:0 and the low parity bit. The upper lane covers address/data bits 63:32, command/byte-enable bits 7:4 and the high parity bit. A narrow bus uses only the lower lane. A wide bus uses both lanes.

The timing follows the bus protocol, where the parity bit arrives one clock after the data it covers:

- **Sample:** on a rising edge, each enabled lane latches the XOR of its data and command/byte-enable bits.
- **Compare:** on the next edge, the latched XOR is combined with the parity bit present then. A set result means the lane saw an odd total, which is a mismatch.
- **Report:** on the edge after that, the mismatches of all lanes are merged into registered flags.

The phase-type input is taken on the sample edge, together with the data. It decides which flag a mismatch sets: a system-error flag for an address phase, or a data-parity-error flag for a data phase. A combined error flag is raised for either kind.

There is no state machine in this block. Each beat moves through a fixed three-edge pipeline: sample, compare, report. A new beat can be sampled on every clock.

Top module: `split_parity_chk`

## Requirements
- R1: While reset is held, and after reset before any beat has been checked, `perr_any`, `sys_err` and `data_err` are 0.
- R2: A beat is checked when `chk_en` = 1 on its sample edge. When the total of its data bits, command/byte-enable bits and parity bit is even in every active lane, all three flags stay 0.
- R3: A beat is sampled on edge E, and its parity bits are present on edge E+1. If that beat has an odd total in an active lane, `perr_any` is 1 for the cycle that follows edge E+2.
- R4: When `chk_en` = 0 on the sample edge, no flag is raised for that beat, whatever its parity.
- R5: When `wide_en` = 0 on the sample edge, the upper lane is ignored. A bad `par_hi` raises no flag.
- R6: When `wide_en` = 1 on the sample edge, an odd total in the upper lane raises the flags even if the lower lane is correct.
- R7: A value of 1 on `addr_phase` at the sample edge marks an address phase. A mismatch in that beat sets `sys_err` = 1 and `data_err` = 0. When `addr_phase` = 0, a mismatch sets `data_err` = 1 and `sys_err` = 0.
- R8: Beats may follow each other on every clock. The flags in each cycle describe only the beat sampled two edges earlier, so a good beat between two bad beats shows 0.
- R9: All-zero data and command/byte-enable bits with parity 0 give no error. The same bits with parity 1 give an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_en | input | 1 | Parity checking enable, taken with the data |
| wide_en | input | 1 | 1 = 64-bit bus (both lanes), 0 = lower lane only |
| addr_phase | input | 1 | 1 = address phase, 0 = data phase, taken with the data |
| ad_in | input | 64 | Multiplexed address/data lines |
| cbe_in | input | 8 | Command/byte-enable lines, bits 3:0 lower lane, 7:4 upper lane |
| par_lo | input | 1 | Even parity bit of the lower lane, one clock after its data |
| par_hi | input | 1 | Even parity bit of the upper lane, one clock after its data |
| perr_any | output | 1 | Any parity mismatch, registered |
| sys_err | output | 1 | Mismatch in an address phase |
| data_err | output | 1 | Mismatch in a data phase |

## Verification
The hardest situation to reach is a stream of beats with no gaps. In that case the parity bit of one beat is on the bus in the same cycle as the data of the next beat, and each verdict must stay tied to its own beat. The driver therefore presents a new beat on every clock and holds back each computed parity bit to the following cycle. Bad, good and disabled beats are mixed back to back, so any slip in the pipeline alignment, or in the phase and width controls, makes a flag land on the wrong cycle.

// File: rtl/par_pkg.sv
package par_pkg;
    localparam int LANE_DW = 32;
    localparam int LANE_BW = 4;
    localparam int N_LANES = 2;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_ADDR = 1'b1
    } phase_e;

    typedef struct packed {
        logic any;
        logic sys;
        logic data;
    } flags_t;
endpackage

// File: rtl/par_lane.sv
module par_lane #(
    parameter int DW = 32,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [DW-1:0] ad_i,
    input  logic [BW-1:0] cbe_i,
    input  logic          par_i,
    output logic          mism_o
);
    logic vld_q;
    logic sum_q;
    logic mism_q;

    // sample stage: fold the lane's data and command bits into one bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            sum_q <= 1'b0;
        end else begin
            vld_q <= en_i;
            sum_q <= ^{ad_i, cbe_i};
        end
    end

    // compare stage: the parity bit arrives one clock after its data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mism_q <= 1'b0;
        end else begin
            mism_q <= vld_q & (sum_q ^ par_i);
        end
    end

    assign mism_o = mism_q;

    // R4
    idle_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |=> !mism_o);
endmodule

// File: rtl/par_report.sv
module par_report
    import par_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mism_i,
    input  phase_e           phase_i,
    output flags_t           flags_o
);
    logic   hit;
    flags_t flags_q;

    assign hit = |mism_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q.any  <= hit;
            flags_q.sys  <= hit && (phase_i == PH_ADDR);
            flags_q.data <= hit && (phase_i == PH_DATA);
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/split_parity_chk.sv
module split_parity_chk
    import par_pkg::*;
#(
    parameter int LANES  = N_LANES,
    parameter int LDW    = LANE_DW,
    parameter int LBW    = LANE_BW,
    localparam int AD_W  = LANES * LDW,
    localparam int CBE_W = LANES * LBW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic             wide_en,
    input  logic             addr_phase,
    input  logic [AD_W-1:0]  ad_in,
    input  logic [CBE_W-1:0] cbe_in,
    input  logic             par_lo,
    input  logic             par_hi,
    output logic             perr_any,
    output logic             sys_err,
    output logic             data_err
);
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] lane_par;
    logic [LANES-1:0] lane_mism;
    phase_e           ph_s1;
    phase_e           ph_s2;
    flags_t           flags;

    // the phase type travels alongside the data through the pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_s1 <= PH_DATA;
            ph_s2 <= PH_DATA;
        end else begin
            ph_s1 <= addr_phase ? PH_ADDR : PH_DATA;
            ph_s2 <= ph_s1;
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            if (g == 0) begin : g_base
                assign lane_en[g]  = chk_en;
                assign lane_par[g] = par_lo;
            end else begin : g_ext
                assign lane_en[g]  = chk_en & wide_en;
                assign lane_par[g] = par_hi;
            end
            par_lane #(.DW(LDW), .BW(LBW)) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .en_i   (lane_en[g]),
                .ad_i   (ad_in[g*LDW +: LDW]),
                .cbe_i  (cbe_in[g*LBW +: LBW]),
                .par_i  (lane_par[g]),
                .mism_o (lane_mism[g])
            );
        end
    endgenerate

    par_report #(.LANES(LANES)) u_report (
        .clk     (clk),
        .rst_n   (rst_n),
        .mism_i  (lane_mism),
        .phase_i (ph_s2),
        .flags_o (flags)
    );

    assign perr_any = flags.any;
    assign sys_err  = flags.sys;
    assign data_err = flags.data;

    // R3
    mism_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_mism) |=> perr_any);

    // R2
    clean_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|lane_mism) |=> !perr_any && !sys_err && !data_err);

    // R7
    addr_to_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lane_mism) && ph_s2 == PH_ADDR) |=> sys_err && !data_err);

    // R7
    data_to_dperr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lane_mism) && ph_s2 == PH_DATA) |=> data_err && !sys_err);
endmodule

// File: tb/tb_split_parity_chk.sv
module tb_split_parity_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b0;
    logic        wide_en = 1'b0;
    logic        addr_phase = 1'b0;
    logic [63:0] ad_in = '0;
    logic [7:0]  cbe_in = '0;
    logic        par_lo = 1'b0;
    logic        par_hi = 1'b0;
    logic        perr_any, sys_err, data_err;

    int   checks = 0;
    int   errors = 0;
    int   edge_cnt = 0;
    bit   done = 1'b0;
    logic pend_lo = 1'b0;
    logic pend_hi = 1'b0;

    int       due_q[$];
    logic [2:0] exp_q[$];
    string    req_q[$];

    always #10 clk = ~clk;

    split_parity_chk dut (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .wide_en(wide_en),
        .addr_phase(addr_phase), .ad_in(ad_in), .cbe_in(cbe_in),
        .par_lo(par_lo), .par_hi(par_hi),
        .perr_any(perr_any), .sys_err(sys_err), .data_err(data_err)
    );

    // drive one beat; its parity bits follow on the next call
    task automatic beat(input logic [63:0] ad, input logic [7:0] cbe,
                        input logic en, input logic wide, input logic ph,
                        input logic bad_lo, input logic bad_hi, input string req);
        logic mlo, mhi, any;
        @(negedge clk);
        ad_in      = ad;
        cbe_in     = cbe;
        chk_en     = en;
        wide_en    = wide;
        addr_phase = ph;
        par_lo     = pend_lo;
        par_hi     = pend_hi;
        pend_lo    = (^{ad[31:0], cbe[3:0]}) ^ bad_lo;
        pend_hi    = (^{ad[63:32], cbe[7:4]}) ^ bad_hi;
        mlo = en & bad_lo;
        mhi = en & wide & bad_hi;
        any = mlo | mhi;
        due_q.push_back(edge_cnt + 3);
        exp_q.push_back({any, any & ph, any & ~ph});
        req_q.push_back(req);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        edge_cnt = edge_cnt + 1;
        #3;
        while (due_q.size() > 0 && due_q[0] == edge_cnt) begin
            logic [2:0] e;
            string r;
            void'(due_q.pop_front());
            e = exp_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if ({perr_any, sys_err, data_err} !== e) begin
                errors++;
                $display("FAIL %s: flags any/sys/data actual=%b expected=%b at edge %0d",
                         r, {perr_any, sys_err, data_err}, e, edge_cnt);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: flags low under reset
        checks++;
        if ({perr_any, sys_err, data_err} !== 3'b000) begin
            errors++;
            $display("FAIL R1: actual=%b expected=000", {perr_any, sys_err, data_err});
        end
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1: still low after reset with no beats
        checks++;
        if ({perr_any, sys_err, data_err} !== 3'b000) begin
            errors++;
            $display("FAIL R1: actual=%b expected=000", {perr_any, sys_err, data_err});
        end

        beat(64'h0, 8'h00, 1, 1, 0, 0, 0, "R9");
        beat(64'h0, 8'h00, 1, 1, 0, 1, 0, "R9");
        beat(64'h0, 8'h00, 1, 0, 0, 0, 0, "R2");
        beat(64'hDEAD_BEEF_0123_4567, 8'hA5, 1, 1, 0, 0, 0, "R2");
        beat(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1, 1, 1, 0, 0, "R2");
        beat(64'h0000_0000_8000_0001, 8'h07, 1, 0, 0, 1, 0, "R3");
        beat(64'h1234_5678_9ABC_DEF0, 8'h3C, 1, 1, 1, 1, 0, "R7");
        beat(64'h1234_5678_9ABC_DEF0, 8'h3C, 1, 1, 0, 1, 0, "R7");
        beat(64'h0F0F_0F0F_F0F0_F0F0, 8'h81, 0, 1, 0, 1, 1, "R4");
        beat(64'h0F0F_0F0F_F0F0_F0F0, 8'h81, 0, 1, 1, 1, 0, "R4");
        beat(64'hCAFE_0000_0000_0000, 8'h50, 1, 0, 0, 0, 1, "R5");
        beat(64'hCAFE_0000_0000_0000, 8'h50, 1, 0, 1, 0, 1, "R5");
        beat(64'hCAFE_0000_0000_0000, 8'h50, 1, 1, 0, 0, 1, "R6");
        beat(64'h8000_0000_0000_0000, 8'h10, 1, 1, 1, 0, 1, "R6");
        beat(64'h5555_AAAA_3333_CCCC, 8'h5A, 1, 1, 0, 1, 0, "R8");
        beat(64'h5555_AAAA_3333_CCCC, 8'h5A, 1, 1, 0, 0, 0, "R8");
        beat(64'h5555_AAAA_3333_CCCC, 8'h5A, 1, 1, 1, 0, 1, "R8");
        beat(64'h0000_0001_0000_0001, 8'h00, 1, 1, 0, 0, 0, "R8");
        beat(64'h0000_0001_0000_0001, 8'h00, 1, 1, 0, 1, 1, "R8");
        for (int i = 0; i < 4; i++) beat(64'h0, 8'h00, 0, 0, 0, 0, 0, "R4");

        while (due_q.size() > 0) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule